// File: doc/BRIEF.md
# Transmit Message Object Scheduler

This block keeps a small bank of transmit message objects for a CAN-style controller and turns the chosen object into a byte stream for the protocol engine. Each object has five registers: two 16-bit identifier halves, a frame-info word whose low nibble is the data length code, a control word, and a buffer base address. The control word holds the remote-frame flag, the interrupt enable and the object enable. Software configures an object through a single write port and then sets its enable bit.

The scheduler chooses the enabled object with the lowest object number. It emits a five-byte header built only from that object's registers. For a data frame it then fetches the payload one byte at a time from buffer memory through a request/grant read port and forwards each byte to the engine's byte sink. A successful frame clears the object's enable and can raise an interrupt. An incoming frame whose identifier matches an enabled remote-frame object cancels that object without an interrupt. This applies both while the object waits and while it is being sent.

The controller has four states. ST_IDLE moves to ST_HEAD on *start* when any object is eligible. ST_HEAD stays in ST_HEAD while header bytes remain (*head_next*). It moves to ST_FETCH after the fifth header byte when payload is due (*head_to_fetch*), or to ST_IDLE when no payload is due (*head_done*). ST_FETCH moves to ST_SEND on *grant*. ST_SEND returns to ST_FETCH for the next byte (*send_next*) or to ST_IDLE after the last byte (*send_done*). Any busy state moves to ST_IDLE on *cancel*.

Top module: `txobj_sched`

## Requirements
- R1: After reset no object is enabled, and tx_valid, tx_abort, mem_req and irq are all low.
- R2: Among enabled, non-cancelled objects, the one with the lowest object number is sent next. The identifier value has no effect on this choice.
- R3: Each frame starts with five header bytes in this order: {rtr, 3'b000, info[3:0]}, then identifier bits [31:24], [23:16], [15:8] and [7:0]. The identifier is {ID high register, ID low register}. Frame-info bits [15:4] have no effect.
- R4: A data frame's payload bytes are read from buffer addresses base+0, base+1 and so on, one request per byte. mem_req stays high with a stable mem_addr until mem_gnt. tx_valid and mem_req are never high together.
- R5: A data length code above 8 results in exactly 8 payload bytes.
- R6: When control bit 0 (remote flag) is set, bit 7 of the first header byte is 1 and no payload is fetched, whatever the length code.
- R7: tx_last marks the final byte of a frame. When that byte is accepted, the object's enable clears. If control bit 1 (interrupt enable) is set, irq pulses for one cycle on the next cycle with irq_obj set to the object number. Otherwise irq stays low.
- R8: A pulse on rx_hit whose rx_id equals the identifier of an enabled, waiting remote-frame object clears that object's enable. No irq is raised for it, and it is never sent.
- R9: If the matching object is the one being sent, tx_valid drops in that cycle and tx_abort pulses. The enable clears and no irq follows. This cancellation takes precedence over acceptance of the final byte in the same cycle.
- R10: Register writes (control bit 2 is the enable) to the object being sent are ignored, so its frame and enable are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_obj | input | OW | Object number written |
| cfg_reg | input | 3 | Register select: 0 ID high, 1 ID low, 2 frame info, 3 control, 4 base |
| cfg_wdata | input | 16 | Write data |
| obj_en | output | NUM_OBJ | Enable bit of each object |
| rx_hit | input | 1 | Incoming frame identifier valid |
| rx_id | input | 32 | Incoming frame identifier |
| tx_valid | output | 1 | Byte offered to engine |
| tx_ready | input | 1 | Engine accepts byte |
| tx_data | output | 8 | Byte to engine |
| tx_last | output | 1 | Final byte of frame |
| tx_abort | output | 1 | Current frame cancelled |
| mem_req | output | 1 | Buffer read request |
| mem_addr | output | ADDR_W | Buffer read address |
| mem_gnt | input | 1 | Read granted, data valid |
| mem_rdata | input | 8 | Buffer read data |
| irq | output | 1 | Completion interrupt pulse |
| irq_obj | output | OW | Object that raised irq |

## Verification
Completion of a remote frame and its cancellation by a matching received identifier can occur in the same cycle. The bench holds tx_ready high and, once tx_valid and tx_last are both up, raises rx_hit with that object's identifier before the clock edge. The correct result is that the final byte is not accepted, tx_abort pulses, the enable clears, and no irq follows. Only the first four header bytes should appear in the captured stream.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_FETCH,
        ST_SEND
    } txs_state_e;

    localparam int HDR_BYTES = 5;
    localparam int MAX_PAY   = 8;

    localparam logic [2:0] REG_ID_HI = 3'd0;
    localparam logic [2:0] REG_ID_LO = 3'd1;
    localparam logic [2:0] REG_INFO  = 3'd2;
    localparam logic [2:0] REG_CTRL  = 3'd3;
    localparam logic [2:0] REG_BASE  = 3'd4;

    localparam int CTRL_RTR = 0;
    localparam int CTRL_IEN = 1;
    localparam int CTRL_EN  = 2;
endpackage

// File: rtl/txs_obj_bank.sv
module txs_obj_bank
    import txs_pkg::*;
#(
    parameter int NUM_OBJ = 4,
    parameter int ADDR_W  = 8,
    localparam int OW     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OW-1:0]     cfg_obj,
    input  logic [2:0]        cfg_reg,
    input  logic [15:0]       cfg_wdata,
    input  logic              busy,
    input  logic [OW-1:0]     act_obj,
    input  logic              done,
    input  logic              rx_hit,
    input  logic [31:0]       rx_id,
    output logic [NUM_OBJ-1:0] en_vec,
    output logic [NUM_OBJ-1:0] cancel_vec,
    output logic [31:0]       act_id,
    output logic [3:0]        act_dlc,
    output logic              act_rtr,
    output logic [ADDR_W-1:0] act_base,
    output logic              irq,
    output logic [OW-1:0]     irq_obj
);
    logic [15:0]       id_hi_q [NUM_OBJ];
    logic [15:0]       id_lo_q [NUM_OBJ];
    logic [3:0]        dlc_q   [NUM_OBJ];
    logic [ADDR_W-1:0] base_q  [NUM_OBJ];
    logic [NUM_OBJ-1:0] rtr_q, ien_q, en_q;
    logic              irq_q;
    logic [OW-1:0]     irq_obj_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OBJ; i++) begin
                id_hi_q[i] <= '0;
                id_lo_q[i] <= '0;
                dlc_q[i]   <= '0;
                base_q[i]  <= '0;
            end
            rtr_q     <= '0;
            ien_q     <= '0;
            en_q      <= '0;
            irq_q     <= 1'b0;
            irq_obj_q <= '0;
        end else begin
            for (int i = 0; i < NUM_OBJ; i++) begin
                if (cfg_we && cfg_obj == OW'(i) && !(busy && act_obj == OW'(i))) begin
                    case (cfg_reg)
                        REG_ID_HI: id_hi_q[i] <= cfg_wdata;
                        REG_ID_LO: id_lo_q[i] <= cfg_wdata;
                        REG_INFO:  dlc_q[i]   <= cfg_wdata[3:0];
                        REG_CTRL: begin
                            rtr_q[i] <= cfg_wdata[CTRL_RTR];
                            ien_q[i] <= cfg_wdata[CTRL_IEN];
                            en_q[i]  <= cfg_wdata[CTRL_EN];
                        end
                        REG_BASE:  base_q[i]  <= cfg_wdata[ADDR_W-1:0];
                        default: ;
                    endcase
                end
                if ((done && act_obj == OW'(i)) || cancel_vec[i])
                    en_q[i] <= 1'b0;
            end
            irq_q     <= done && ien_q[act_obj];
            irq_obj_q <= act_obj;
        end
    end

    for (genvar gi = 0; gi < NUM_OBJ; gi++) begin : g_obj
        assign cancel_vec[gi] = rx_hit && en_q[gi] && rtr_q[gi] &&
                                ({id_hi_q[gi], id_lo_q[gi]} == rx_id);

        assert_cancel_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cancel_vec[gi] |=> !en_q[gi]);
    end

    assign en_vec   = en_q;
    assign act_id   = {id_hi_q[act_obj], id_lo_q[act_obj]};
    assign act_dlc  = dlc_q[act_obj];
    assign act_rtr  = rtr_q[act_obj];
    assign act_base = base_q[act_obj];
    assign irq      = irq_q;
    assign irq_obj  = irq_obj_q;

    assert_irq_follows_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(done));
endmodule

// File: rtl/txs_prearb.sv
module txs_prearb #(
    parameter int NUM_OBJ = 4,
    localparam int OW     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic [NUM_OBJ-1:0] req,
    output logic               any,
    output logic [OW-1:0]      idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_OBJ - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = OW'(i);
            end
        end
    end

    always_comb begin
        if (any && !$isunknown(req)) begin
            assert_lowest_wins_R2: assert (req[idx] &&
                ((req & ((NUM_OBJ'(1) << idx) - NUM_OBJ'(1))) == '0));
        end
    end
endmodule

// File: rtl/txs_tx_fsm.sv
module txs_tx_fsm
    import txs_pkg::*;
#(
    parameter int NUM_OBJ = 4,
    parameter int ADDR_W  = 8,
    localparam int OW     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_any,
    input  logic [OW-1:0]      start_idx,
    input  logic [NUM_OBJ-1:0] cancel_vec,
    input  logic [31:0]        act_id,
    input  logic [3:0]         act_dlc,
    input  logic               act_rtr,
    input  logic [ADDR_W-1:0]  act_base,
    output logic               busy,
    output logic [OW-1:0]      act_obj,
    output logic               done,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    output logic               tx_abort,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_gnt,
    input  logic [7:0]         mem_rdata
);
    txs_state_e state_q, nxt_state;
    logic [OW-1:0] act_q, nxt_act;
    logic [2:0]    cnt_q, nxt_cnt;
    logic [3:0]    idx_q, nxt_idx;
    logic [7:0]    data_q, nxt_data;
    logic [3:0]    n_pay;
    logic [7:0]    hdr_byte;
    logic          cancel_act;

    localparam logic [2:0] HDR_END = 3'(HDR_BYTES - 1);

    assign n_pay      = act_rtr ? 4'd0 : ((act_dlc > 4'(MAX_PAY)) ? 4'(MAX_PAY) : act_dlc);
    assign cancel_act = cancel_vec[act_q] && (state_q != ST_IDLE);
    assign busy       = state_q != ST_IDLE;
    assign act_obj    = act_q;
    assign mem_addr   = act_base + ADDR_W'(idx_q);

    always_comb begin
        case (cnt_q)
            3'd0:    hdr_byte = {act_rtr, 3'b000, act_dlc};
            3'd1:    hdr_byte = act_id[31:24];
            3'd2:    hdr_byte = act_id[23:16];
            3'd3:    hdr_byte = act_id[15:8];
            default: hdr_byte = act_id[7:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= nxt_state;
            act_q   <= nxt_act;
            cnt_q   <= nxt_cnt;
            idx_q   <= nxt_idx;
            data_q  <= nxt_data;
        end
    end

    always_comb begin
        nxt_state = state_q;
        nxt_act   = act_q;
        nxt_cnt   = cnt_q;
        nxt_idx   = idx_q;
        nxt_data  = data_q;
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        tx_last   = 1'b0;
        tx_abort  = 1'b0;
        mem_req   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_any) begin
                    nxt_state = ST_HEAD;
                    nxt_act   = start_idx;
                    nxt_cnt   = '0;
                    nxt_idx   = '0;
                end
            end
            ST_HEAD: begin
                if (cancel_act) begin
                    tx_abort  = 1'b1;
                    nxt_state = ST_IDLE;
                end else begin
                    tx_valid = 1'b1;
                    tx_data  = hdr_byte;
                    tx_last  = (cnt_q == HDR_END) && (n_pay == 4'd0);
                    if (tx_ready) begin
                        if (cnt_q == HDR_END) begin
                            if (n_pay == 4'd0) begin
                                done      = 1'b1;
                                nxt_state = ST_IDLE;
                            end else begin
                                nxt_state = ST_FETCH;
                            end
                        end else begin
                            nxt_cnt = cnt_q + 3'd1;
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (cancel_act) begin
                    tx_abort  = 1'b1;
                    nxt_state = ST_IDLE;
                end else begin
                    mem_req = 1'b1;
                    if (mem_gnt) begin
                        nxt_data  = mem_rdata;
                        nxt_state = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (cancel_act) begin
                    tx_abort  = 1'b1;
                    nxt_state = ST_IDLE;
                end else begin
                    tx_valid = 1'b1;
                    tx_data  = data_q;
                    tx_last  = (idx_q == n_pay - 4'd1);
                    if (tx_ready) begin
                        if (tx_last) begin
                            done      = 1'b1;
                            nxt_state = ST_IDLE;
                        end else begin
                            nxt_idx   = idx_q + 4'd1;
                            nxt_state = ST_FETCH;
                        end
                    end
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && mem_req));
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> ((mem_req || tx_abort) && $stable(mem_addr)));
    assert_remote_no_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && act_rtr) |-> !mem_req);
    assert_done_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_valid && tx_ready && tx_last));
endmodule

// File: rtl/txobj_sched.sv
module txobj_sched #(
    parameter int NUM_OBJ = 4,
    parameter int ADDR_W  = 8,
    localparam int OW     = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [OW-1:0]      cfg_obj,
    input  logic [2:0]         cfg_reg,
    input  logic [15:0]        cfg_wdata,
    output logic [NUM_OBJ-1:0] obj_en,
    input  logic               rx_hit,
    input  logic [31:0]        rx_id,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    output logic               tx_abort,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_gnt,
    input  logic [7:0]         mem_rdata,
    output logic               irq,
    output logic [OW-1:0]      irq_obj
);
    logic [NUM_OBJ-1:0] en_vec, cancel_vec;
    logic               busy, done, start_any;
    logic [OW-1:0]      act_obj, start_idx;
    logic [31:0]        act_id;
    logic [3:0]         act_dlc;
    logic               act_rtr;
    logic [ADDR_W-1:0]  act_base;

    txs_obj_bank #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_obj(cfg_obj), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .busy(busy), .act_obj(act_obj), .done(done),
        .rx_hit(rx_hit), .rx_id(rx_id),
        .en_vec(en_vec), .cancel_vec(cancel_vec),
        .act_id(act_id), .act_dlc(act_dlc), .act_rtr(act_rtr), .act_base(act_base),
        .irq(irq), .irq_obj(irq_obj)
    );

    txs_prearb #(.NUM_OBJ(NUM_OBJ)) u_arb (
        .req(en_vec & ~cancel_vec), .any(start_any), .idx(start_idx)
    );

    txs_tx_fsm #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_any(start_any), .start_idx(start_idx), .cancel_vec(cancel_vec),
        .act_id(act_id), .act_dlc(act_dlc), .act_rtr(act_rtr), .act_base(act_base),
        .busy(busy), .act_obj(act_obj), .done(done),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_abort(tx_abort),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    assign obj_en = en_vec;

    assert_abort_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !irq);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !tx_valid));
endmodule

// File: tb/test_txobj_sched.sv
`timescale 1ns/1ps
module test_txobj_sched;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int OW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [OW-1:0] cfg_obj = '0;
    logic [2:0] cfg_reg = '0;
    logic [15:0] cfg_wdata = '0;
    logic [N-1:0] obj_en;
    logic rx_hit = 1'b0;
    logic [31:0] rx_id = '0;
    logic tx_valid, tx_last, tx_abort, mem_req, irq;
    logic tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic [AW-1:0] mem_addr;
    logic mem_gnt = 1'b0;
    logic [7:0] mem_rdata;
    logic [OW-1:0] irq_obj;

    txobj_sched #(.NUM_OBJ(N), .ADDR_W(AW)) i_txobj_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_obj(cfg_obj),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .obj_en(obj_en),
        .rx_hit(rx_hit), .rx_id(rx_id), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .tx_abort(tx_abort),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .irq(irq), .irq_obj(irq_obj)
    );

    always #5 clk = ~clk;

    logic [7:0] mem [256];
    assign mem_rdata = mem[mem_addr];

    logic [15:0] sh_hi [N];
    logic [15:0] sh_lo [N];
    logic [15:0] sh_info [N];
    logic        sh_rtr [N];
    logic        sh_ien [N];
    logic [7:0]  sh_base [N];

    logic [7:0] cap_q[$];
    logic [7:0] exp_q[$];
    int total = 0, bad = 0;
    int irq_cnt = 0, abort_cnt = 0;
    logic [OW-1:0] irq_last = '0;
    int mode = 1;
    logic rx_pend = 1'b0;
    logic [31:0] rx_pend_id = '0;
    logic [31:0] auto_id = '0;
    bit finished = 0;

    // Input driver and sampler: everything moves at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = (mode == 0) ? 1'($urandom % 2) : (mode >= 2);
            mem_gnt  = ($urandom % 3) != 0;
            rx_hit   = rx_pend;
            rx_id    = rx_pend_id;
            rx_pend  = 1'b0;
            #1;
            if (mode == 4 && tx_valid && tx_last) begin
                rx_hit = 1'b1;
                rx_id  = auto_id;
                #1;
            end
            if (tx_valid && tx_ready) cap_q.push_back(tx_data);
            if (irq) begin irq_cnt++; irq_last = irq_obj; end
            if (tx_abort) abort_cnt++;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int o, logic [2:0] r, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_obj = OW'(o); cfg_reg = r; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(int o, logic [15:0] hi, logic [15:0] lo, logic [15:0] info,
                         logic rtr, logic ien, logic [7:0] base);
        sh_hi[o] = hi; sh_lo[o] = lo; sh_info[o] = info;
        sh_rtr[o] = rtr; sh_ien[o] = ien; sh_base[o] = base;
        wr(o, 3'd0, hi);
        wr(o, 3'd1, lo);
        wr(o, 3'd2, info);
        wr(o, 3'd4, {8'h00, base});
        wr(o, 3'd3, {13'b0, 1'b0, ien, rtr});
    endtask

    task automatic enable(int o);
        wr(o, 3'd3, {13'b0, 1'b1, sh_ien[o], sh_rtr[o]});
    endtask

    function automatic int pay_len(int o);
        if (sh_rtr[o]) return 0;
        return (sh_info[o][3:0] > 8) ? 8 : int'(sh_info[o][3:0]);
    endfunction

    task automatic exp_frame(int o);
        exp_q.push_back({sh_rtr[o], 3'b000, sh_info[o][3:0]});
        exp_q.push_back(sh_hi[o][15:8]);
        exp_q.push_back(sh_hi[o][7:0]);
        exp_q.push_back(sh_lo[o][15:8]);
        exp_q.push_back(sh_lo[o][7:0]);
        for (int j = 0; j < pay_len(o); j++)
            exp_q.push_back(mem[8'(sh_base[o] + 8'(j))]);
    endtask

    task automatic cmp_stream(string req, string what);
        int mis = -1;
        if (cap_q.size() == exp_q.size()) begin
            for (int j = 0; j < cap_q.size(); j++)
                if (mis < 0 && cap_q[j] !== exp_q[j]) mis = j;
            if (mis < 0) chk(1, req, what, 0, 0);
            else chk(0, req, {what, " byte"}, cap_q[mis], exp_q[mis]);
        end else begin
            chk(0, req, {what, " length"}, cap_q.size(), exp_q.size());
        end
        cap_q.delete();
        exp_q.delete();
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && obj_en != '0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        cap_q.delete();
        exp_q.delete();
    endtask

    initial begin
        int ic;
        int ac;
        process::self().srandom(32'd1234);
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        #2;
        chk(obj_en == '0, "R1", "obj_en", obj_en, 0);
        chk(!tx_valid && !mem_req, "R1", "tx_valid|mem_req", {tx_valid, mem_req}, 0);
        chk(!irq && !tx_abort, "R1", "irq|abort", {irq, tx_abort}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(obj_en == '0 && !tx_valid, "R1", "after release", obj_en, 0);

        // R3 R4 R7: data frame, upper info bits ignored
        mode = 0; clear_all();
        setup(2, 16'h1234, 16'h5678, 16'hABC3, 0, 1, 8'h40);
        ic = irq_cnt;
        enable(2); exp_frame(2); wait_idle();
        cmp_stream("R3", "data frame obj2");
        chk(irq_cnt == ic + 1, "R7", "irq count", irq_cnt - ic, 1);
        chk(irq_last == 2, "R7", "irq_obj", irq_last, 2);

        // R5: clamp, interrupt disabled
        setup(0, 16'h0F0F, 16'hF0F0, 16'h000C, 0, 0, 8'hFC);
        ic = irq_cnt;
        enable(0); exp_frame(0); wait_idle();
        cmp_stream("R5", "length clamp");
        chk(irq_cnt == ic, "R7", "no irq when disabled", irq_cnt - ic, 0);

        // R6: remote frame, no payload
        setup(1, 16'h0001, 16'h0002, 16'h0005, 1, 1, 8'h10);
        ic = irq_cnt;
        enable(1); exp_frame(1); wait_idle();
        cmp_stream("R6", "remote frame");
        chk(irq_cnt == ic + 1, "R7", "remote irq", irq_cnt - ic, 1);

        // R2: lowest number wins, identifier ignored
        mode = 1;
        setup(0, 16'hFFFF, 16'hFFFF, 16'h0001, 0, 0, 8'h00);
        setup(1, 16'h8000, 16'h0000, 16'h0002, 0, 0, 8'h20);
        setup(3, 16'h0000, 16'h0001, 16'h0001, 0, 0, 8'h30);
        enable(0); repeat (2) @(negedge clk);
        enable(3); enable(1);
        exp_frame(0); exp_frame(1); exp_frame(3);
        mode = 0; wait_idle();
        cmp_stream("R2", "object order");

        // R8: pending remote object cancelled
        mode = 1;
        setup(0, 16'h1111, 16'h2222, 16'h0001, 0, 1, 8'h50);
        setup(2, 16'hCAFE, 16'hBEEF, 16'h0003, 1, 1, 8'h00);
        ic = irq_cnt;
        enable(0); enable(2);
        rx_pend_id = 32'hCAFEBEEF; rx_pend = 1'b1;
        repeat (3) @(negedge clk);
        chk(obj_en[2] == 1'b0, "R8", "pending enable cleared", obj_en[2], 0);
        exp_frame(0);
        mode = 0; wait_idle();
        cmp_stream("R8", "only data frame sent");
        chk(irq_cnt == ic + 1 && irq_last == 0, "R8", "irq only from obj0", irq_cnt - ic, 1);

        // R9: active remote object cancelled
        mode = 1; clear_all();
        setup(1, 16'h00AA, 16'h5500, 16'h0002, 1, 1, 8'h00);
        ic = irq_cnt; ac = abort_cnt;
        enable(1); repeat (3) @(negedge clk);
        rx_pend_id = 32'h00AA5500; rx_pend = 1'b1;
        repeat (6) @(negedge clk);
        chk(abort_cnt == ac + 1, "R9", "abort pulse", abort_cnt - ac, 1);
        chk(obj_en == '0, "R9", "enable cleared", obj_en, 0);
        chk(irq_cnt == ic, "R9", "no irq", irq_cnt - ic, 0);
        cmp_stream("R9", "nothing sent");

        // R10: writes to the active object ignored
        mode = 1;
        setup(3, 16'h3333, 16'h4444, 16'h0002, 0, 1, 8'h60);
        enable(3); repeat (3) @(negedge clk);
        wr(3, 3'd3, 16'h0000);
        wr(3, 3'd0, 16'h9999);
        @(negedge clk);
        chk(obj_en[3] == 1'b1, "R10", "enable kept", obj_en[3], 1);
        exp_frame(3);
        mode = 0; wait_idle();
        cmp_stream("R10", "frame unchanged");

        // R9: cancel in the cycle the final byte would be accepted
        mode = 1; clear_all();
        setup(2, 16'h7777, 16'h1357, 16'h0000, 1, 1, 8'h00);
        ic = irq_cnt; ac = abort_cnt;
        auto_id = 32'h77771357;
        enable(2); mode = 4;
        repeat (12) @(negedge clk);
        mode = 1;
        exp_frame(2); void'(exp_q.pop_back());
        chk(abort_cnt == ac + 1, "R9", "same-cycle abort", abort_cnt - ac, 1);
        chk(irq_cnt == ic, "R9", "same-cycle no irq", irq_cnt - ic, 0);
        chk(obj_en[2] == 1'b0, "R9", "same-cycle enable", obj_en[2], 0);
        cmp_stream("R9", "four header bytes only");

        // Random mixes: R2 R3 R4 R5 R6 R7
        for (int it = 0; it < 12; it++) begin
            logic [N-1:0] m;
            int first;
            int nie;
            m = N'($urandom % 15 + 1);
            first = 0; nie = 0;
            mode = 1; clear_all();
            for (int o = 0; o < N; o++) begin
                if (m[o]) begin
                    setup(o, 16'($urandom), 16'($urandom), 16'($urandom),
                          1'($urandom % 3 == 0), 1'($urandom % 2), 8'($urandom));
                    first = o;
                    if (sh_ien[o]) nie++;
                end
            end
            ic = irq_cnt;
            enable(first); repeat (2) @(negedge clk);
            exp_frame(first);
            for (int o = 0; o < N; o++)
                if (m[o] && o != first) begin enable(o); exp_frame(o); end
            mode = 0; wait_idle();
            cmp_stream("R2", "random stream");
            chk(irq_cnt == ic + nie, "R7", "random irq count", irq_cnt - ic, nie);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog run did not end actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule